// File: doc/BRIEF.md
# Loop Replay Controller for Decoded Control Words

This block sits between the instruction decoder and the execute stage of a small processor pipeline and removes fetch and decode activity from the repeated passes of a hardware loop. When a loop begins, the decoded control word of each body instruction is stored in a small on-chip buffer, slot by slot, while it also goes straight on to execute. Once the body has been seen once, the block drops the fetch and decode enables and feeds execute from the buffer, pass after pass, until the iteration count runs out.

The loop is described by a start marker on the first body instruction, an end marker on the last one, the body length and the total number of iterations. Bodies that do not fit the buffer run normally through fetch and decode on every pass. A stall freezes the block, and a second loop start while a loop is in progress is ignored. On exit the enables come back one cycle before the buffer lets go of the output, so the first instruction after the loop follows the last replayed word with no gap.

Top module: `loop_replay_ctrl`

## Requirements
- R1: After reset `ex_word` is 0 and `fetch_en` and `decode_en` are 1; outside a loop, `ex_word` shows the `dec_word` of each non-stalled cycle in the following cycle.
- R2: A `loop_start` in a non-stalled cycle with `body_len` from 1 to DEPTH (16) and `iter_count` of 2 or more stores the `dec_word` of that cycle and of the next `body_len`-1 non-stalled cycles in slots 0 upwards, each word also reaching `ex_word` one cycle later.
- R3: `fetch_en` and `decode_en` fall together in the cycle after the last body word is stored and stay low for the whole replay.
- R4: During replay each non-stalled cycle puts the next stored word on `ex_word` in slot order, wrapping to slot 0 after slot `body_len`-1, for `iter_count`-1 passes in total.
- R5: `fetch_en` and `decode_en` rise in the cycle the final replayed word is on `ex_word`; the next non-stalled cycle shows the live `dec_word` again.
- R6: With `body_len` of 0 or above DEPTH, or `iter_count` below 2, nothing is stored, the enables stay 1 and words pass straight through; a long body stays tracked as an active loop until its `iter_count`-th `loop_end`.
- R7: While `stall` is 1 the outputs hold, no pointer or count moves, no slot is written and markers are ignored.
- R8: A `loop_start` during a loop already in progress (storing, replaying or tracking a long body) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Pipeline hold; freezes the block |
| dec_word | input | W | Decoded control word from the decoder |
| loop_start | input | 1 | Marks the first body instruction of a loop |
| loop_end | input | 1 | Marks the last body instruction of a pass |
| body_len | input | LEN_W | Loop body length in instructions, sampled at start |
| iter_count | input | CNT_W | Total loop passes, sampled at start |
| ex_word | output | W | Control word to the execute stage |
| fetch_en | output | 1 | Instruction fetch enable |
| decode_en | output | 1 | Instruction decode enable |

## Verification
A wrong slot pointer or pass count shows on `ex_word` within one cycle as a word out of the stored order, or as a replay that is one pass too short or too long, which the per-cycle reference comparison catches at the first wrong word. A wrong state shows on the enables: fetch turned off during a pass-through loop or left on during replay is visible the same cycle. Exit timing errors appear as either a repeated word or a skipped live word in the cycle after the last replay, so the bench compares every cycle around the loop boundaries, including stalled ones.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic [1:0] {
    LS_IDLE   = 2'd0,
    LS_FILL   = 2'd1,
    LS_REPLAY = 2'd2,
    LS_LONG   = 2'd3
  } lr_state_t;
endpackage

// File: rtl/lrc_store.sv
// Slot memory with synchronous write and registered read, shaped for block RAM.
module lrc_store #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= slots[raddr];
  end
endmodule

// File: rtl/lrc_seq.sv
// Loop state machine: fill pointer, replay pointer, pass count, enables.
module lrc_seq
  import lrc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LEN_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             loop_start,
  input  logic             loop_end,
  input  logic [LEN_W-1:0] body_len,
  input  logic [CNT_W-1:0] iter_count,
  output lr_state_t        st,
  output logic             mem_we,
  output logic [AW-1:0]    waddr,
  output logic             mem_re,
  output logic [AW-1:0]    raddr,
  output logic             use_buf,
  output logic [AW-1:0]    cap_ptr,
  output logic [AW-1:0]    last_idx,
  output logic             fetch_on
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
  localparam logic [CNT_W-1:0] TWO_C   = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [AW-1:0]    rd_ptr;
  logic [CNT_W-1:0] rem;
  logic             fits, many, long_body, go;

  always_comb begin
    fits      = (body_len != '0) && (body_len <= DEPTH_L);
    long_body = (body_len > DEPTH_L);
    many      = (iter_count >= TWO_C);
    go        = !stall && loop_start && (st == LS_IDLE);
  end

  always_comb begin
    mem_we  = !stall && ((go && fits && many) || (st == LS_FILL));
    waddr   = (st == LS_FILL) ? cap_ptr : '0;
    mem_re  = !stall && (st == LS_REPLAY);
    raddr   = rd_ptr;
    use_buf = (st == LS_REPLAY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= LS_IDLE;
      cap_ptr  <= '0;
      rd_ptr   <= '0;
      last_idx <= '0;
      rem      <= '0;
      fetch_on <= 1'b1;
    end else if (!stall) begin
      unique case (st)
        LS_IDLE: begin
          if (go && fits && many) begin
            last_idx <= AW'(body_len - 1'b1);
            rem      <= iter_count - ONE_C;
            rd_ptr   <= '0;
            if (body_len == LEN_W'(1)) begin
              st       <= LS_REPLAY;
              fetch_on <= 1'b0;
            end else begin
              st      <= LS_FILL;
              cap_ptr <= AW'(1);
            end
          end else if (go && long_body && many) begin
            st  <= LS_LONG;
            rem <= iter_count;
          end
        end
        LS_FILL: begin
          if (cap_ptr == last_idx) begin
            st       <= LS_REPLAY;
            fetch_on <= 1'b0;
          end else begin
            cap_ptr <= cap_ptr + AW'(1);
          end
        end
        LS_REPLAY: begin
          if (rd_ptr == last_idx) begin
            rd_ptr <= '0;
            if (rem == ONE_C) begin
              st       <= LS_IDLE;
              fetch_on <= 1'b1;
            end else begin
              rem <= rem - ONE_C;
            end
          end else begin
            rd_ptr <= rd_ptr + AW'(1);
          end
        end
        LS_LONG: begin
          if (loop_end) begin
            if (rem == ONE_C) st <= LS_IDLE;
            else              rem <= rem - ONE_C;
          end
        end
        default: st <= LS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrc_outsel.sv
// Output selector: registered live word and registered source select.
module lrc_outsel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         use_buf,
  input  logic [W-1:0] dec_word,
  input  logic [W-1:0] buf_word,
  output logic [W-1:0] ex_word,
  output logic         sel_q
);
  logic [W-1:0] live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      sel_q  <= 1'b0;
    end else if (adv) begin
      sel_q <= use_buf;
      if (!use_buf) live_q <= dec_word;
    end
  end

  always_comb ex_word = sel_q ? buf_word : live_q;
endmodule

// File: rtl/loop_replay_ctrl.sv
module loop_replay_ctrl
  import lrc_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int LEN_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic [W-1:0]     dec_word,
  input  logic             loop_start,
  input  logic             loop_end,
  input  logic [LEN_W-1:0] body_len,
  input  logic [CNT_W-1:0] iter_count,
  output logic [W-1:0]     ex_word,
  output logic             fetch_en,
  output logic             decode_en
);
  localparam int AW = $clog2(DEPTH);

  lr_state_t     st;
  logic          mem_we, mem_re, use_buf, buf_sel, fetch_on;
  logic [AW-1:0] waddr, raddr, cap_ptr, last_idx;
  logic [W-1:0]  buf_word;

  lrc_seq #(.DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .stall(stall),
    .loop_start(loop_start), .loop_end(loop_end),
    .body_len(body_len), .iter_count(iter_count),
    .st(st), .mem_we(mem_we), .waddr(waddr),
    .mem_re(mem_re), .raddr(raddr), .use_buf(use_buf),
    .cap_ptr(cap_ptr), .last_idx(last_idx), .fetch_on(fetch_on)
  );

  lrc_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(dec_word),
    .re(mem_re), .raddr(raddr), .rdata(buf_word)
  );

  lrc_outsel #(.W(W)) u_out (
    .clk(clk), .rst(rst), .adv(!stall), .use_buf(use_buf),
    .dec_word(dec_word), .buf_word(buf_word),
    .ex_word(ex_word), .sel_q(buf_sel)
  );

  always_comb begin
    fetch_en  = fetch_on;
    decode_en = fetch_on;
  end
endmodule

// File: rtl/lrc_chk.sv
module lrc_chk
  import lrc_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          loop_start,
  input logic [W-1:0]  ex_word,
  input logic          fetch_en,
  input logic          decode_en,
  input lr_state_t     st,
  input logic          mem_we,
  input logic [AW-1:0] cap_ptr,
  input logic [AW-1:0] last_idx,
  input logic [AW-1:0] raddr,
  input logic          buf_sel
);
  // R3
  fetch_off_replay_chk: assert property (@(posedge clk) disable iff (rst)
    (st == LS_REPLAY) |-> (!fetch_en && !decode_en));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(ex_word) && $stable(fetch_en)));

  // R7
  no_write_stall_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !mem_we);

  // R5
  exit_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_en) |-> buf_sel);

  // R5
  release_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_sel) |-> fetch_en);

  // R4
  replay_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st == LS_REPLAY) |-> (raddr <= last_idx));

  // R2
  fill_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st == LS_FILL) |-> ((cap_ptr <= last_idx) && (cap_ptr != '0)));

  // R8
  nest_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st == LS_FILL && !stall && loop_start && cap_ptr != last_idx) |=> (st == LS_FILL));
endmodule

bind loop_replay_ctrl lrc_chk #(.W(W), .AW($clog2(DEPTH))) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .loop_start(loop_start),
  .ex_word(ex_word), .fetch_en(fetch_en), .decode_en(decode_en),
  .st(st), .mem_we(mem_we), .cap_ptr(cap_ptr), .last_idx(last_idx),
  .raddr(raddr), .buf_sel(buf_sel)
);

// File: tb/loop_replay_ctrl_test.sv
`timescale 1ns/1ps
module loop_replay_ctrl_test;
  localparam int W = 32;
  localparam int DEPTH = 16;
  localparam int LEN_W = 6;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stall = 1'b0;
  logic [W-1:0]     dec_word = '0;
  logic             loop_start = 1'b0;
  logic             loop_end = 1'b0;
  logic [LEN_W-1:0] body_len = '0;
  logic [CNT_W-1:0] iter_count = '0;
  logic [W-1:0]     ex_word;
  logic             fetch_en, decode_en;

  always #10 clk = ~clk;

  loop_replay_ctrl #(.W(W), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .stall(stall), .dec_word(dec_word),
    .loop_start(loop_start), .loop_end(loop_end),
    .body_len(body_len), .iter_count(iter_count),
    .ex_word(ex_word), .fetch_en(fetch_en), .decode_en(decode_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wctr = 1;

  // Behavioural reference: 0 outside, 1 storing, 2 replaying, 3 long body
  int            mode = 0;
  logic [W-1:0]  body[$];
  int            m_len, m_idx, m_rem;
  logic [W-1:0]  exp_ex = '0;
  logic          exp_fe = 1'b1;
  string         tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      mode = 0; exp_ex = '0; exp_fe = 1'b1; tag = "R1";
    end else if (stall) begin
      tag = "R7";
    end else begin
      case (mode)
        0: begin
          exp_ex = dec_word; tag = "R1";
          if (loop_start) begin
            if (body_len >= 1 && body_len <= DEPTH && iter_count >= 2) begin
              body.delete(); body.push_back(dec_word);
              m_len = int'(body_len); m_rem = int'(iter_count) - 1; m_idx = 0;
              tag = "R2";
              if (m_len == 1) begin mode = 2; exp_fe = 1'b0; tag = "R3"; end
              else mode = 1;
            end else begin
              tag = "R6";
              if (body_len > DEPTH && iter_count >= 2) begin
                mode = 3; m_rem = int'(iter_count);
              end
            end
          end
        end
        1: begin
          exp_ex = dec_word; tag = loop_start ? "R8" : "R2";
          body.push_back(dec_word);
          if (body.size() == m_len) begin mode = 2; exp_fe = 1'b0; tag = "R3"; end
        end
        2: begin
          exp_ex = body[m_idx]; tag = loop_start ? "R8" : "R4";
          if (m_idx == m_len - 1) begin
            m_idx = 0;
            if (m_rem == 1) begin mode = 0; exp_fe = 1'b1; tag = "R5"; end
            else m_rem--;
          end else m_idx++;
        end
        default: begin
          exp_ex = dec_word; tag = loop_start ? "R8" : "R6";
          if (loop_end) begin
            if (m_rem == 1) mode = 0;
            else m_rem--;
          end
        end
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(tag, "ex_word", ex_word, exp_ex);
    chk(tag, "fetch_en", W'(fetch_en), W'(exp_fe));
    chk(tag, "decode_en", W'(decode_en), W'(exp_fe));
  end

  task automatic tick(input logic s, input logic ls, input logic le);
    @(negedge clk);
    stall = s; loop_start = ls; loop_end = le;
    dec_word = W'(32'hA500_0000 + wctr);
    wctr++;
  endtask

  task automatic run_loop(input int len, input int iters, input int stall_every,
                          input bit nest, input int idle);
    int k = 0;
    body_len = LEN_W'(len); iter_count = CNT_W'(iters);
    for (int p = 0; p < iters; p++) begin
      for (int i = 0; i < len; i++) begin
        if (stall_every > 0 && (k % stall_every) == stall_every - 1) tick(1'b1, 1'b1, 1'b1);
        tick(1'b0, (p == 0 && i == 0) || (nest && p == 0 && i == 1) || (nest && p == 1 && i == 0),
             i == len - 1);
        k++;
      end
    end
    for (int j = 0; j < idle; j++) tick(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired before the sequence finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values seen before release
    chk("R1", "reset ex_word", ex_word, '0);
    chk("R1", "reset fetch_en", W'(fetch_en), W'(1'b1));
    rst = 1'b0;
    for (int j = 0; j < 4; j++) tick(1'b0, 1'b0, 1'b0);
    run_loop(4, 3, 0, 1'b0, 3);    // R2 R3 R4 R5
    run_loop(1, 2, 0, 1'b0, 2);    // single-word body
    run_loop(16, 2, 3, 1'b1, 3);   // full buffer, stalls (R7), nested start (R8)
    run_loop(20, 2, 4, 1'b1, 3);   // R6 long body, R8 in long
    run_loop(3, 1, 0, 1'b0, 2);    // R6 single pass
    run_loop(0, 3, 0, 1'b0, 0);    // no body cycles
    tick(1'b0, 1'b1, 1'b0);        // R6 zero length start
    tick(1'b0, 1'b0, 1'b0);
    run_loop(5, 4, 2, 1'b1, 0);    // stalls in replay
    run_loop(2, 2, 0, 1'b0, 0);    // back-to-back loops
    run_loop(3, 2, 0, 1'b0, 4);
    @(negedge clk);
    // R5: after the final exit the block is back in pass-through
    chk("R5", "fetch_en after exit", W'(fetch_en), W'(1'b1));
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule